// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences a small microcontroller-style system through its low-power modes. Software, or a CPU-side front end, issues a one-cycle request with a two-bit mode code. The block then walks the system into the chosen mode and later walks it back out. There are three such modes. In a light doze only the processor clock stops. In a retained halt the whole core clock domain stops and every clock source is shut off, but supply and contents stay. In the deepest mode the regulator is turned off and the core domain is cut from its supply.

The block drives the clock-gate enables for the CPU and the core domain. It also drives the enables of the PLL, the internal RC oscillator and the external crystal oscillator, the regulator mode, and the core power switch. Each mode listens to its own set of wake sources. Leaving the retained halt resumes on the internal RC oscillator once that oscillator reports ready. Leaving the deepest mode restores power, waits for the regulator to report ready, and then issues a system reset pulse. It also sets a sticky flag in the backup domain.

The block runs on the always-on clock. The real-time clock, the independent watchdog and their clock sources are never touched by it, so they keep running in every mode. The oscillators and the regulator are outside the block; it only drives their enables and samples their ready inputs.

Top module: `lp_seq`

## Requirements
- R1: After power-on reset the system is in run: `cpu_clk_en`, `core_clk_en`, `pll_en`, `hsi_en`, `hse_en`, `reg_normal` and `pwr_sw_on` are 1, and `sys_rst` and `stby_flag` are 0.
- R2: A request with `req_mode` = 2'b01 in run clears only `cpu_clk_en` from the next cycle. While in this mode, `irq_any` high returns `cpu_clk_en` to 1 on the next cycle.
- R3: A request with `req_mode` = 2'b10 in run has two steps. In the first cycle after the request, both clock enables are 0 and the oscillator enables are unchanged. From the following cycle, `pll_en`, `hsi_en` and `hse_en` are 0, while `reg_normal` and `pwr_sw_on` stay 1.
- R4: The retained halt is left when any `ext_line` bit, `volt_mon`, `rtc_alarm` or `usb_wake` is high. In that case `hsi_en` is 1 on the next cycle with the clocks still gated. `irq_any` and `wdt_rst` do not end this mode.
- R5: After leaving the retained halt, both clock enables become 1 in the cycle after `hsi_rdy` is sampled high. `pll_en` and `hse_en` then stay 0 until a reset that ends the deepest mode.
- R6: A request with `req_mode` = 2'b11 in run gates both clocks in the first cycle and leaves the oscillators on. From the next cycle, `reg_normal`, `pwr_sw_on` and all oscillator enables are 0.
- R7: The deepest mode is left on `ext_rst_req`, `wdt_rst`, `rtc_alarm`, or a rising edge of `wkup_pin`. The pin passes two synchroniser flops and an edge flop, so a rise acts on the third clock edge after it. A level that was already high before entry does not wake the block, and `ext_line` is ignored in this mode.
- R8: On leaving the deepest mode, `pwr_sw_on` and `reg_normal` return to 1 at once. After `reg_rdy` is sampled high, `sys_rst` is 1 for exactly RST_CYCLES (default 4) consecutive cycles. The system is then in run with all oscillator enables at 1.
- R9: `stby_flag` goes to 1 when the reset pulse of R8 starts and holds through it. A `flag_clr` pulse clears it. If setting and clearing fall on the same cycle, the set wins.
- R10: A request made while not in run is ignored, and a request with `req_mode` = 2'b00 has no effect.
- R11: If a wake source of the target mode is high during the first entry cycle of R3 or R6, the entry is abandoned. The system is back in run on the next cycle, and the oscillators are never disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| req_valid | input | 1 | One-cycle low-power entry request |
| req_mode | input | 2 | Mode code: 00 run, 01 sleep, 10 halt, 11 deepest |
| irq_any | input | 1 | Any enabled interrupt or event |
| ext_line | input | N_EXT | External wake lines |
| volt_mon | input | 1 | Voltage monitor output |
| rtc_alarm | input | 1 | Real-time clock alarm |
| usb_wake | input | 1 | USB wake signal |
| ext_rst_req | input | 1 | External reset pin request |
| wdt_rst | input | 1 | Independent watchdog reset |
| wkup_pin | input | 1 | Asynchronous wake pin |
| hsi_rdy | input | 1 | Internal RC oscillator ready |
| reg_rdy | input | 1 | Regulator ready |
| flag_clr | input | 1 | Write-one-to-clear for the standby flag |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_clk_en | output | 1 | Core domain clock gate enable |
| pll_en | output | 1 | PLL enable |
| hsi_en | output | 1 | Internal RC oscillator enable |
| hse_en | output | 1 | External crystal oscillator enable |
| reg_normal | output | 1 | Regulator in normal mode (0 = off) |
| pwr_sw_on | output | 1 | Core domain power switch closed |
| sys_rst | output | 1 | System reset pulse |
| stby_flag | output | 1 | Sticky backup-domain flag for deepest-mode exit |

## Verification
The hardest cases to reach are the single entry cycle, when clocks are already gated but the oscillators are still on, and the difference between an edge and a level on the wake pin. For the abort cases, the bench raises the target mode's wake source before it issues the request, so that the source is present in exactly that entry cycle. For the wake pin, the bench holds the pin high across a whole deepest-mode entry and confirms that nothing happens. In a later entry it raises the pin, then samples the power switch after each of the three edges to find the cycle in which exit begins. Because the PLL and crystal enables stay off after a retained halt, the bench tracks them in its own expected state across scenarios.

// File: rtl/lp_seq.sv
module lp_seq #(
  parameter int N_EXT      = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk_aon,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             irq_any,
  input  logic [N_EXT-1:0] ext_line,
  input  logic             volt_mon,
  input  logic             rtc_alarm,
  input  logic             usb_wake,
  input  logic             ext_rst_req,
  input  logic             wdt_rst,
  input  logic             wkup_pin,
  input  logic             hsi_rdy,
  input  logic             reg_rdy,
  input  logic             flag_clr,
  output logic             cpu_clk_en,
  output logic             core_clk_en,
  output logic             pll_en,
  output logic             hsi_en,
  output logic             hse_en,
  output logic             reg_normal,
  output logic             pwr_sw_on,
  output logic             sys_rst,
  output logic             stby_flag
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

  typedef enum logic [3:0] {
    S_RUN, S_DOZE, S_HALT_IN, S_HALT, S_HALT_OUT,
    S_DEEP_IN, S_DEEP, S_DEEP_PWR, S_DEEP_RST
  } st_t;

  st_t st, st_nx;
  logic [2:0]    wk_q;
  logic [CW-1:0] cnt;
  logic          fast_osc;

  wire wk_rise   = wk_q[1] & ~wk_q[2];
  wire halt_wake = (|ext_line) | volt_mon | rtc_alarm | usb_wake;
  wire deep_wake = ext_rst_req | wdt_rst | rtc_alarm | wk_rise;

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:
        if (req_valid) begin
          case (req_mode)
            2'b01:   st_nx = S_DOZE;
            2'b10:   st_nx = S_HALT_IN;
            2'b11:   st_nx = S_DEEP_IN;
            default: st_nx = S_RUN;
          endcase
        end
      S_DOZE:     if (irq_any)   st_nx = S_RUN;
      S_HALT_IN:  st_nx = halt_wake ? S_RUN : S_HALT;
      S_HALT:     if (halt_wake) st_nx = S_HALT_OUT;
      S_HALT_OUT: if (hsi_rdy)   st_nx = S_RUN;
      S_DEEP_IN:  st_nx = deep_wake ? S_RUN : S_DEEP;
      S_DEEP:     if (deep_wake) st_nx = S_DEEP_PWR;
      S_DEEP_PWR: if (reg_rdy)   st_nx = S_DEEP_RST;
      S_DEEP_RST: if (cnt == CNT_LAST) st_nx = S_RUN;
      default:    st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      wk_q      <= '0;
      cnt       <= '0;
      fast_osc  <= 1'b1;
      stby_flag <= 1'b0;
    end else begin
      st   <= st_nx;
      wk_q <= {wk_q[1:0], wkup_pin};
      cnt  <= (st == S_DEEP_RST) ? cnt + 1'b1 : '0;
      if (st == S_HALT_IN && st_nx == S_HALT)
        fast_osc <= 1'b0;
      else if (st == S_DEEP_RST && st_nx == S_RUN)
        fast_osc <= 1'b1;
      if (st == S_DEEP_PWR && reg_rdy)
        stby_flag <= 1'b1;
      else if (flag_clr)
        stby_flag <= 1'b0;
    end
  end

  wire clocks_on = (st == S_RUN) || (st == S_DOZE);
  wire osc_live  = clocks_on || (st == S_HALT_IN) || (st == S_DEEP_IN);
  wire supply_on = (st != S_DEEP);

  assign cpu_clk_en  = (st == S_RUN);
  assign core_clk_en = clocks_on;
  assign hsi_en      = osc_live || (st == S_HALT_OUT) || (st == S_DEEP_RST);
  assign pll_en      = osc_live && fast_osc;
  assign hse_en      = osc_live && fast_osc;
  assign reg_normal  = supply_on;
  assign pwr_sw_on   = supply_on;
  assign sys_rst     = (st == S_DEEP_RST);
endmodule

module lp_seq_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic clk_aon,
  input logic rst_n,
  input logic irq_any,
  input logic cpu_clk_en,
  input logic core_clk_en,
  input logic pll_en,
  input logic hsi_en,
  input logic hse_en,
  input logic reg_normal,
  input logic pwr_sw_on,
  input logic sys_rst,
  input logic stby_flag
);
  logic [7:0] hi_cnt;
  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (sys_rst) hi_cnt <= (hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  assert_cpu_needs_core_R2: assert property (@(posedge clk_aon) disable iff (!rst_n)
    cpu_clk_en |-> core_clk_en);
  assert_osc_off_gated_R3: assert property (@(posedge clk_aon) disable iff (!rst_n)
    !hsi_en |-> (!core_clk_en && !cpu_clk_en));
  assert_pll_back_only_by_reset_R5: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(pll_en) |-> $past(sys_rst));
  assert_power_off_all_off_R6: assert property (@(posedge clk_aon) disable iff (!rst_n)
    !pwr_sw_on |-> (!reg_normal && !hsi_en && !pll_en && !hse_en));
  assert_reset_pulse_len_R8: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $fell(sys_rst) |-> (hi_cnt >= 8'(RST_CYCLES)));
  assert_flag_at_reset_R9: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(sys_rst) |-> stby_flag);
  assert_doze_holds_R10: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (!cpu_clk_en && core_clk_en && !irq_any) |=> (!cpu_clk_en && core_clk_en));
endmodule

bind lp_seq lp_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/lp_seq_test.sv
`timescale 1ns/1ps
module lp_seq_test;
  localparam int N_EXT = 16;
  localparam int RSTC  = 4;

  logic clk_aon = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, irq_any = 0, volt_mon = 0, rtc_alarm = 0, usb_wake = 0;
  logic ext_rst_req = 0, wdt_rst = 0, wkup_pin = 0, hsi_rdy = 0, reg_rdy = 0, flag_clr = 0;
  logic [1:0] req_mode = 2'b00;
  logic [N_EXT-1:0] ext_line = '0;
  logic cpu_clk_en, core_clk_en, pll_en, hsi_en, hse_en, reg_normal, pwr_sw_on, sys_rst, stby_flag;

  int checks = 0, fails = 0;
  logic exp_fast = 1'b1;

  always #10 clk_aon = ~clk_aon;

  lp_seq #(.N_EXT(N_EXT), .RST_CYCLES(RSTC)) uut (.*);

  task automatic tick(); @(negedge clk_aon); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {cpu_clk_en, core_clk_en, pll_en, hsi_en, hse_en, reg_normal, pwr_sw_on, sys_rst};
  endfunction

  function automatic logic [7:0] run_exp();
    return {1'b1, 1'b1, exp_fast, 1'b1, exp_fast, 1'b1, 1'b1, 1'b0};
  endfunction

  task automatic request(logic [1:0] m);
    req_valid = 1; req_mode = m; tick(); req_valid = 0; req_mode = 2'b00;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
    chk("R1 outputs", outs(), 8'b1111_1110);
    chk("R1 flag", stby_flag, 0);
  endtask

  task automatic t_doze();
    request(2'b01);
    chk("R2 doze gates cpu only", outs(), run_exp() & 8'b0111_1111);
    request(2'b10);
    chk("R10 request in doze ignored", outs(), run_exp() & 8'b0111_1111);
    tick();
    chk("R10 still dozing", core_clk_en, 1);
    irq_any = 1; tick(); irq_any = 0;
    chk("R2 irq wakes", outs(), run_exp());
  endtask

  task automatic t_halt(int src);
    request(2'b10);
    chk("R3 entry step", outs(), run_exp() & 8'b0011_1111);
    tick();
    chk("R3 halted", outs(), 8'b0000_0110);
    exp_fast = 0;
    irq_any = 1; wdt_rst = 1; tick(); irq_any = 0; wdt_rst = 0;
    chk("R4 irq/wdt ignored", hsi_en, 0);
    case (src)
      0: ext_line[0] = 1;
      1: ext_line[N_EXT-1] = 1;
      2: volt_mon = 1;
      3: rtc_alarm = 1;
      default: usb_wake = 1;
    endcase
    tick();
    ext_line = '0; volt_mon = 0; rtc_alarm = 0; usb_wake = 0;
    chk("R4 wake starts rc", outs(), 8'b0001_0110);
    tick();
    chk("R5 waits rc ready", core_clk_en, 0);
    hsi_rdy = 1; tick(); hsi_rdy = 0;
    chk("R5 resumed on rc", outs(), 8'b1101_0110);
  endtask

  task automatic t_halt_abort();
    ext_line[3] = 1;
    request(2'b10);
    chk("R11 halt entry step", outs(), run_exp() & 8'b0011_1111);
    tick();
    chk("R11 halt aborted", outs(), run_exp());
    ext_line = '0;
  endtask

  task automatic t_deep(int src);
    int n;
    request(2'b11);
    chk("R6 entry step", outs(), run_exp() & 8'b0011_1111);
    tick();
    chk("R6 deep", outs(), 8'b0000_0000);
    ext_line = '1; volt_mon = 1; tick(); ext_line = '0; volt_mon = 0;
    chk("R7 ext lines ignored", pwr_sw_on, 0);
    if (src == 3) begin
      wkup_pin = 1; tick(); tick();
      chk("R7 wkup not yet", pwr_sw_on, 0);
      tick();
      chk("R7 wkup third edge", pwr_sw_on, 1);
    end else begin
      case (src)
        0: ext_rst_req = 1;
        1: wdt_rst = 1;
        default: rtc_alarm = 1;
      endcase
      tick(); ext_rst_req = 0; wdt_rst = 0; rtc_alarm = 0;
    end
    chk("R8 power restored", outs(), 8'b0000_0110);
    tick();
    chk("R8 waits regulator", sys_rst, 0);
    reg_rdy = 1; tick(); reg_rdy = 0;
    chk("R9 flag at reset start", stby_flag, 1);
    n = 0;
    while (sys_rst && n < 20) begin n++; tick(); end
    chk("R8 reset length", n, RSTC);
    exp_fast = 1;
    chk("R8 back in run", outs(), run_exp());
    chk("R9 flag held", stby_flag, 1);
    wkup_pin = 0;
  endtask

  task automatic t_wkup_level();
    wkup_pin = 1; repeat (3) tick();
    request(2'b11); tick();
    repeat (4) tick();
    chk("R7 level does not wake", pwr_sw_on, 0);
    rtc_alarm = 1; tick(); rtc_alarm = 0;
    chk("R7 rtc wakes", pwr_sw_on, 1);
    reg_rdy = 1; tick(); reg_rdy = 0;
    repeat (RSTC) tick();
    exp_fast = 1;
    chk("R8 run after rtc exit", outs(), run_exp());
    wkup_pin = 0; tick();
  endtask

  task automatic t_flag();
    flag_clr = 1; tick(); flag_clr = 0;
    chk("R9 flag cleared", stby_flag, 0);
    request(2'b11); tick();
    wdt_rst = 1; tick(); wdt_rst = 0;
    reg_rdy = 1; flag_clr = 1; tick(); reg_rdy = 0; flag_clr = 0;
    chk("R9 set wins over clear", stby_flag, 1);
    repeat (RSTC) tick();
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  task automatic t_deep_abort();
    rtc_alarm = 1;
    request(2'b11);
    chk("R11 deep entry step", outs(), run_exp() & 8'b0011_1111);
    tick();
    chk("R11 deep aborted", outs(), run_exp());
    rtc_alarm = 0;
  endtask

  task automatic t_mode0();
    request(2'b00);
    chk("R10 mode 00 no effect", outs(), run_exp());
    tick();
    chk("R10 still run", outs(), run_exp());
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mode0();
    t_doze();
    for (int s = 0; s < 5; s++) t_halt(s);
    t_halt_abort();
    for (int s = 0; s < 4; s++) t_deep(s);
    t_wkup_level();
    t_deep_abort();
    t_flag();
    t_doze();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule